// File: doc/BRIEF.md
# AC-Link Input Frame Serializer

This block is the codec-side transmitter of the AC-link input stream. It runs on the serial bit clock and watches the frame-sync line. When it sees sync rise, it sends one 256-bit frame, one bit per clock, on a single serial data output. The frame opens with a 16-bit tag slot. The tag holds a codec-ready flag and one valid flag for each of the twelve 20-bit data slots that follow.

The parent block supplies the ready flag, the twelve valid flags and a flat vector with the payloads of slots 1 to 11. Slot 12 is not taken from that vector. It is built from per-line status inputs (GPIO, ring, hook, caller-ID path, loop-current change), two frame-detect flags and a GPIO change interrupt, each at a fixed bit position. All inputs are copied into a shadow register at the frame-start edge. The parent may therefore change them while a frame is on the wire.

Top module: `ac_in_serializer`

## Requirements
- R1: A frame is 256 bits long: a 16-bit tag slot, then slots 1 to 12 of 20 bits each. Every slot is sent MSB first.
- R2: The sync line is sampled on each falling edge of the bit clock. When a falling edge sees sync high and the previous falling edge saw it low, the first tag bit is launched on the next rising edge. The following bits are launched one per rising edge.
- R3: Tag bit 15, the first bit of the frame, equals `codec_ready_i` as captured at frame start.
- R4: Tag bits 14 down to 3 carry the valid flags of slots 1 to 12 in that order. Tag bit 14 carries `slot_valid_i[0]` and tag bit 3 carries `slot_valid_i[11]`. The valid flag of a silent slot is sent as 0. Tag bits 2 to 0 are 0.
- R5: Slots 1, 2, 5 and 10 carry their payload word. Slot s is `slot_data_i[(s-1)*20 +: 20]`.
- R6: Slots 3, 4, 6, 7, 8, 9 and 11 are silent. They are sent as all zeros whatever their payload.
- R7: Slot 12 is built as follows:
  - bits 19:14 are `line2_stat_i[5:0]`;
  - bits 13:10 are 0;
  - bits 9:4 are `line1_stat_i[5:0]`;
  - bit 3 is 0;
  - bit 2 is `frame_det_i[1]` and bit 1 is `frame_det_i[0]`;
  - bit 0 is `gpio_irq_i`.

  Within each status field, bit 5 is spare GPIO B, bit 4 is spare GPIO A, bit 3 is the loop-current change flag, bit 2 is the caller-ID path enable, bit 1 is ring detect and bit 0 is off-hook.
- R8: Every input is captured at frame start. Changing an input while its frame is being sent has no effect on that frame.
- R9: `sdata_o` is 0 while reset is asserted and while no frame is being sent, including the clock after the last bit of a frame.
- R10: A new sync rising edge seen in the middle of a frame abandons that frame. A new frame starts from tag bit 15 under the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync, changes on the rising clock edge |
| codec_ready_i | input | 1 | Codec ready flag for tag bit 15 |
| slot_valid_i | input | 12 | Valid flags for slots 1 to 12 |
| slot_data_i | input | 220 | Payload words of slots 1 to 11 |
| line1_stat_i | input | 6 | Line 1 status field of slot 12 |
| line2_stat_i | input | 6 | Line 2 status field of slot 12 |
| frame_det_i | input | 2 | Frame-detect flags, bit 0 for line 1 |
| gpio_irq_i | input | 1 | GPIO state-change interrupt |
| sdata_o | output | 1 | Serial input-frame data |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots and the fixed silent-slot mask. With these values a whole frame is only 256 clocks long. The bench can therefore compare every bit position of every frame against a reference it computes itself. It sweeps a walking one across the twelve valid flags and across all fifteen status bits of slot 12, so every tag position and every status position is checked on its own. Further runs invert all inputs in mid-frame, restart a frame with a second sync edge, and assert reset in mid-frame.

// File: rtl/ac_in_pkg.sv
package ac_in_pkg;
  localparam int unsigned TAG_BITS   = 16;
  localparam int unsigned SLOT_BITS  = 20;
  localparam int unsigned DATA_SLOTS = 12;
  // slots 3,4,6,7,8,9,11 (bit k = slot k+1)
  localparam logic [DATA_SLOTS-1:0] SILENT_SLOTS = 12'h5EC;

  typedef struct packed {
    logic gpio_b;
    logic gpio_a;
    logic loop_delta;
    logic cid_en;
    logic ring;
    logic off_hook;
  } line_stat_t;

  localparam int unsigned LINE_BITS = $bits(line_stat_t);

  function automatic logic [19:0] pack_status(line_stat_t l2, line_stat_t l1,
                                              logic [1:0] fdet, logic irq);
    return {l2, 4'b0000, l1, 1'b0, fdet, irq};
  endfunction
endpackage

// File: rtl/ac_in_sync_det.sv
module ac_in_sync_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic start_o
);
  logic sync_q, start_q;

  // sampled on the falling edge; start_q spans exactly one rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sync_q  <= sync_i;
      start_q <= sync_i & ~sync_q;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/ac_in_frame_pos.sv
module ac_in_frame_pos #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned N_SLOTS = 12,
  parameter int unsigned BIT_W   = 5,
  parameter int unsigned SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             launch_o,
  output logic [SEL_W-1:0] slot_o,
  output logic [BIT_W-1:0] bit_o
);
  logic             active_q, last;
  logic [SEL_W-1:0] slot_q, cur_slot;
  logic [BIT_W-1:0] bit_q, cur_bit;

  assign cur_slot = start_i ? '0 : slot_q;
  assign cur_bit  = start_i ? BIT_W'(TAG_W - 1) : bit_q;
  assign launch_o = start_i | active_q;
  assign last     = (cur_slot == SEL_W'(N_SLOTS)) && (cur_bit == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else if (launch_o) begin
      active_q <= ~last;
      if (cur_bit == '0) begin
        slot_q <= cur_slot + SEL_W'(1);
        bit_q  <= BIT_W'(SLOT_W - 1);
      end else begin
        slot_q <= cur_slot;
        bit_q  <= cur_bit - BIT_W'(1);
      end
    end
  end

  assign slot_o = cur_slot;
  assign bit_o  = cur_bit;
endmodule

// File: rtl/ac_in_slot_mux.sv
module ac_in_slot_mux #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned SLOT_W  = 20,
  parameter int unsigned N_SLOTS = 12,
  parameter logic [N_SLOTS-1:0] ZERO_MASK = '0,
  parameter int unsigned BIT_W   = 5,
  parameter int unsigned SEL_W   = 4
) (
  input  logic                      ready_i,
  input  logic [N_SLOTS-1:0]        valid_i,
  input  logic [N_SLOTS*SLOT_W-1:0] words_i,
  input  logic [SEL_W-1:0]          slot_i,
  input  logic [BIT_W-1:0]          bit_i,
  output logic                      bit_o
);
  logic [TAG_W-1:0]  tag;
  logic [SLOT_W-1:0] word [N_SLOTS+1];

  always_comb begin
    tag            = '0;
    tag[TAG_W-1]   = ready_i;
    for (int k = 0; k < N_SLOTS; k++) begin
      tag[TAG_W-2-k] = valid_i[k] & ~ZERO_MASK[k];
    end
  end

  assign word[0] = {{(SLOT_W-TAG_W){1'b0}}, tag};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    if (ZERO_MASK[g]) begin : g_silent
      assign word[g+1] = '0;
    end else begin : g_live
      assign word[g+1] = words_i[g*SLOT_W +: SLOT_W];
    end
  end

  assign bit_o = word[slot_i][bit_i];
endmodule

// File: rtl/ac_in_serializer.sv
module ac_in_serializer #(
  parameter int unsigned TAG_W   = ac_in_pkg::TAG_BITS,
  parameter int unsigned SLOT_W  = ac_in_pkg::SLOT_BITS,
  parameter int unsigned N_SLOTS = ac_in_pkg::DATA_SLOTS,
  parameter logic [N_SLOTS-1:0] ZERO_MASK = ac_in_pkg::SILENT_SLOTS,
  parameter int unsigned LINE_W  = ac_in_pkg::LINE_BITS
) (
  input  logic                          bclk_i,
  input  logic                          rst_ni,
  input  logic                          sync_i,
  input  logic                          codec_ready_i,
  input  logic [N_SLOTS-1:0]            slot_valid_i,
  input  logic [(N_SLOTS-1)*SLOT_W-1:0] slot_data_i,
  input  logic [LINE_W-1:0]             line1_stat_i,
  input  logic [LINE_W-1:0]             line2_stat_i,
  input  logic [1:0]                    frame_det_i,
  input  logic                          gpio_irq_i,
  output logic                          sdata_o
);
  import ac_in_pkg::*;

  localparam int unsigned BIT_W = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W);
  localparam int unsigned SEL_W = $clog2(N_SLOTS + 1);
  localparam int unsigned ALL_W = N_SLOTS * SLOT_W;

  logic             start, launch, mux_bit, sdata_q;
  logic [SEL_W-1:0] cur_slot;
  logic [BIT_W-1:0] cur_bit;

  logic               sh_ready, src_ready;
  logic [N_SLOTS-1:0] sh_valid, src_valid;
  logic [ALL_W-1:0]   live_words, sh_words, src_words;

  assign live_words = {SLOT_W'(pack_status(line_stat_t'(line2_stat_i),
                                           line_stat_t'(line1_stat_i),
                                           frame_det_i, gpio_irq_i)),
                       slot_data_i};

  // first bit of a frame comes straight from the inputs being captured
  assign src_ready = start ? codec_ready_i : sh_ready;
  assign src_valid = start ? slot_valid_i  : sh_valid;
  assign src_words = start ? live_words    : sh_words;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_ready <= 1'b0;
      sh_valid <= '0;
      sh_words <= '0;
    end else if (start) begin
      sh_ready <= codec_ready_i;
      sh_valid <= slot_valid_i;
      sh_words <= live_words;
    end
  end

  ac_in_sync_det i_sync_det (
    .clk_i   (bclk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .start_o (start)
  );

  ac_in_frame_pos #(
    .TAG_W   (TAG_W),
    .SLOT_W  (SLOT_W),
    .N_SLOTS (N_SLOTS),
    .BIT_W   (BIT_W),
    .SEL_W   (SEL_W)
  ) i_frame_pos (
    .clk_i    (bclk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .launch_o (launch),
    .slot_o   (cur_slot),
    .bit_o    (cur_bit)
  );

  ac_in_slot_mux #(
    .TAG_W     (TAG_W),
    .SLOT_W    (SLOT_W),
    .N_SLOTS   (N_SLOTS),
    .ZERO_MASK (ZERO_MASK),
    .BIT_W     (BIT_W),
    .SEL_W     (SEL_W)
  ) i_slot_mux (
    .ready_i (src_ready),
    .valid_i (src_valid),
    .words_i (src_words),
    .slot_i  (cur_slot),
    .bit_i   (cur_bit),
    .bit_o   (mux_bit)
  );

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) sdata_q <= 1'b0;
    else         sdata_q <= launch & mux_bit;
  end

  assign sdata_o = sdata_q;
endmodule

// File: rtl/ac_in_serializer_chk.sv
module ac_in_serializer_chk #(
  parameter int unsigned TAG_W   = 16,
  parameter int unsigned N_SLOTS = 12,
  parameter logic [N_SLOTS-1:0] ZERO_MASK = '0,
  parameter int unsigned BIT_W   = 5,
  parameter int unsigned SEL_W   = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             launch_i,
  input logic [SEL_W-1:0] slot_i,
  input logic [BIT_W-1:0] bit_i,
  input logic             ready_i,
  input logic             sdata_i
);
  function automatic logic silent(logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N_SLOTS; k++) begin
      if (int'(s) == k + 1) r = ZERO_MASK[k];
    end
    return r;
  endfunction

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> (int'(slot_i) <= N_SLOTS)); // R1

  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> launch_i); // R2

  AST_READY_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sdata_i == $past(ready_i))); // R3

  AST_TAG_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && slot_i == '0 && int'(bit_i) < TAG_W - 1 - N_SLOTS) |=> !sdata_i); // R4

  AST_SILENT_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && silent(slot_i)) |=> !sdata_i); // R6

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !launch_i |=> !sdata_i); // R9
endmodule

bind ac_in_serializer ac_in_serializer_chk #(
  .TAG_W     (TAG_W),
  .N_SLOTS   (N_SLOTS),
  .ZERO_MASK (ZERO_MASK),
  .BIT_W     (BIT_W),
  .SEL_W     (SEL_W)
) i_chk (
  .clk_i    (bclk_i),
  .rst_ni   (rst_ni),
  .start_i  (start),
  .launch_i (launch),
  .slot_i   (cur_slot),
  .bit_i    (cur_bit),
  .ready_i  (codec_ready_i),
  .sdata_i  (sdata_o)
);

// File: tb/test_ac_in_serializer.sv
`timescale 1ns/1ps
module test_ac_in_serializer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         sync;
  logic         ready;
  logic [11:0]  valid;
  logic [219:0] sdata_in;
  logic [5:0]   l1, l2;
  logic [1:0]   fdet;
  logic         irq;
  logic         sdata;

  int checks = 0;
  int errors = 0;

  // snapshot of inputs at frame start
  logic         e_ready;
  logic [11:0]  e_valid;
  logic [219:0] e_data;
  logic [5:0]   e_l1, e_l2;
  logic [1:0]   e_fdet;
  logic         e_irq;
  logic [0:255] got;

  always #10 clk = ~clk;

  ac_in_serializer i_ac_in_serializer (
    .bclk_i        (clk),
    .rst_ni        (rst_n),
    .sync_i        (sync),
    .codec_ready_i (ready),
    .slot_valid_i  (valid),
    .slot_data_i   (sdata_in),
    .line1_stat_i  (l1),
    .line2_stat_i  (l2),
    .frame_det_i   (fdet),
    .gpio_irq_i    (irq),
    .sdata_o       (sdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_silent(int s);
    return s == 3 || s == 4 || s == 6 || s == 7 || s == 8 || s == 9 || s == 11;
  endfunction

  function automatic logic exp_bit(int p);
    logic [19:0] st;
    int tb, q, s, b;
    if (p < 16) begin
      tb = 15 - p;
      if (tb == 15) return e_ready;
      if (tb >= 3) begin
        s = 15 - tb;
        return is_silent(s) ? 1'b0 : e_valid[s-1];
      end
      return 1'b0;
    end
    q = p - 16;
    s = q / 20 + 1;
    b = 19 - (q % 20);
    if (is_silent(s)) return 1'b0;
    if (s < 12) return e_data[(s-1)*20 + b];
    st = {e_l2, 4'b0000, e_l1, 1'b0, e_fdet, e_irq};
    return st[b];
  endfunction

  task automatic check_frame(input string tag);
    logic [11:0] gv, ev;
    logic [19:0] gw, ew;
    string req;
    check(got[0] == exp_bit(0), {"R3 ", tag}, 32'(got[0]), 32'(exp_bit(0)));
    for (int i = 0; i < 12; i++) begin
      gv[11-i] = got[1+i];
      ev[11-i] = exp_bit(1+i);
    end
    check(gv == ev, {"R4 valid ", tag}, 32'(gv), 32'(ev));
    check(got[13:15] == 3'b000, {"R4 tail ", tag}, 32'(got[13:15]), 0);
    for (int s = 1; s <= 12; s++) begin
      for (int b = 0; b < 20; b++) begin
        gw[19-b] = got[16 + (s-1)*20 + b];
        ew[19-b] = exp_bit(16 + (s-1)*20 + b);
      end
      req = is_silent(s) ? "R6" : (s == 12 ? "R7" : "R5");
      check(gw == ew, $sformatf("R1 R2 R8 %s slot%0d %s", req, s, tag), 32'(gw), 32'(ew));
    end
  endtask

  task automatic scramble();
    ready    = ~ready;
    valid    = ~valid;
    sdata_in = ~sdata_in;
    l1 = ~l1; l2 = ~l2; fdet = ~fdet; irq = ~irq;
  endtask

  task automatic run_frame(input int stop_at, input bit chk, input string tag);
    e_ready = ready; e_valid = valid; e_data = sdata_in;
    e_l1 = l1; e_l2 = l2; e_fdet = fdet; e_irq = irq;
    @(posedge clk); #1 sync = 1'b1;
    for (int i = 0; i < stop_at; i++) begin
      @(posedge clk); #1;
      if (i == 16)  sync = 1'b0;
      if (i == 100) scramble();
      @(negedge clk);
      if (i < 256) got[i] = sdata;
      else if (chk) check(sdata == 1'b0, {"R9 idle ", tag}, 32'(sdata), 0);
    end
    if (chk) check_frame(tag);
  endtask

  task automatic set_data(input int seed);
    for (int s = 0; s < 11; s++) begin
      sdata_in[s*20 +: 20] = 20'((s * 37 + seed) * 193'd1 * 32'h0002_F3B1);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sync = 1'b0; ready = 1'b0; valid = '0; sdata_in = '0;
    l1 = '0; l2 = '0; fdet = '0; irq = 1'b0;
    repeat (3) @(negedge clk);
    check(sdata == 1'b0, "R9 in reset", 32'(sdata), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdata == 1'b0, "R9 idle after reset", 32'(sdata), 0);

    run_frame(258, 1, "zeros");

    ready = 1'b1; valid = '1; sdata_in = '1; l1 = '1; l2 = '1; fdet = '1; irq = 1'b1;
    run_frame(258, 1, "ones");

    ready = 1'b1; valid = 12'hA5A;
    for (int s = 0; s < 11; s++) sdata_in[s*20 +: 20] = 20'hAAAAA;
    l1 = 6'h2A; l2 = 6'h15; fdet = 2'b10; irq = 1'b0;
    run_frame(258, 1, "alt");

    for (int k = 0; k < 12; k++) begin
      ready = k[0]; valid = 12'(1 << k); set_data(k);
      l1 = '0; l2 = '0; fdet = '0; irq = 1'b0;
      run_frame(258, 1, $sformatf("walk_valid%0d", k));
    end

    valid = 12'h3C3; ready = 1'b1; set_data(99);
    for (int k = 0; k < 15; k++) begin
      {l2, l1, fdet, irq} = 15'(1 << k);
      run_frame(258, 1, $sformatf("walk_stat%0d", k));
    end

    // R10: second sync edge in mid-frame
    set_data(7); valid = '1; ready = 1'b1;
    run_frame(60, 0, "abandoned");
    set_data(55); valid = 12'h0F3; ready = 1'b0; l1 = 6'h11; l2 = 6'h22;
    run_frame(258, 1, "R10 restart");

    // R9: reset in mid-frame
    ready = 1'b1; valid = '1; sdata_in = '1;
    @(posedge clk); #1 sync = 1'b1;
    repeat (30) @(posedge clk);
    #1 rst_n = 1'b0; sync = 1'b0;
    #2 check(sdata == 1'b0, "R9 reset mid-frame", 32'(sdata), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sdata == 1'b0, "R9 idle after mid-frame reset", 32'(sdata), 0);

    set_data(3); valid = 12'h5A5; ready = 1'b1;
    run_frame(258, 1, "post_reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule